// File: doc/BRIEF.md
# Debug Port System Status Register

This block is a read-only 8-bit status word for a debug access port. It collects live information from the system domain into one register: whether a system reset has occurred, whether the domain sleeps, whether boot has finished, whether a chip erase failed, whether the device is locked, and whether NVM or user-row programming may begin over the debug link. A debugger reads the word with a read strobe and an address, and the block returns the word only when the address matches.

Some bits are sticky, some follow levels, one is cleared by reading it, and the top bit is a summary derived from two others. The block also drives a registered access-grant output. It keeps the debugger away from the access layer until boot has completed and no system reset is pending.

Bit layout of the word: bit 7 summary, bit 6 erase failed, bit 5 system reset seen, bit 4 sleeping, bit 3 NVM programming allowed, bit 2 user-row programming allowed, bit 1 boot done, bit 0 locked.

Top module: `dbg_sys_status`

## Requirements
- R1: After rst_ni is released, a read at address 0x0B returns 0x01, with only bit 0 (locked) set, and acc_grant_o is 0.
- R2: Bit 7 always reads as bit 6 OR bit 1.
- R3: An erase_fail_evt_i pulse sets bit 6 from the next cycle, and the bit stays set. While hold_rst_i is 1 the bit is cleared, and it cannot be set in that cycle, because the clear wins over the set.
- R4: A sys_rst_evt_i pulse or a high hold_rst_i sets bit 5 from the next cycle. A read at 0x0B returns the current value and clears bit 5 from the next cycle. A set in the same cycle as the read wins over the clear.
- R5: Bits 4, 3 and 2 show sleep_i, nvm_prog_ok_i and urow_prog_ok_i as they were one cycle earlier.
- R6: A boot_done_evt_i pulse sets bit 1 from the next cycle, and the bit stays set until rst_ni.
- R7: Bit 0 is 1 after reset. On a lock_upd_i strobe it takes the value of lock_val_i from the next cycle, so it reads 0 after an erase that leaves the lock bits clear.
- R8: acc_grant_o equals bit 1 AND NOT bit 5 as they were one cycle earlier.
- R9: With rd_en_i low, or with an address other than 0x0B, rd_data_o is 0x00 and bit 5 is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register address of the read |
| rd_data_o | output | 8 | Read data, 0x00 when not addressed |
| sys_rst_evt_i | input | 1 | Pulse: a system-domain reset occurred |
| hold_rst_i | input | 1 | Level: the debug reset request is being held |
| erase_fail_evt_i | input | 1 | Pulse: a chip-erase attempt failed |
| boot_done_evt_i | input | 1 | Pulse: the CPU finished its boot sequence |
| sleep_i | input | 1 | Level: the system domain is idle or in deeper sleep |
| nvm_prog_ok_i | input | 1 | Level: NVM programming may start |
| urow_prog_ok_i | input | 1 | Level: user-row programming may start |
| lock_upd_i | input | 1 | Strobe: load a new lock state |
| lock_val_i | input | 1 | Lock state to load |
| acc_grant_o | output | 1 | Registered access-layer grant |

## Verification
The assertions check the following on every cycle:
- the one-cycle set and clear of the reset flag, including that a same-cycle set beats the read clear;
- the priority of the held reset over an erase failure;
- the loading of the lock bit;
- the one-cycle lag of the access grant;
- the zero data returned on a miss.

Only the bench's scenarios can show the rest:
- the reset value;
- the summary bit combined with the other fields in one read;
- the level bits walked through their combinations;
- that a read returns the value from before the clear;
- that a missed read leaves a pending reset flag to be seen by a later read.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef struct packed {
    logic summary;
    logic erase_fail;
    logic sys_rst;
    logic sleeping;
    logic nvm_prog_ok;
    logic urow_prog_ok;
    logic boot_done;
    logic locked;
  } status_t;

  localparam int unsigned STATUS_W = $bits(status_t);
  localparam int unsigned LVL_W    = 3;
  localparam status_t     STATUS_RST = '{locked: 1'b1, default: 1'b0};
endpackage

// File: rtl/dss_flag.sv
module dss_flag #(
  parameter bit SET_WINS = 1'b1,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb q_d = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
    end else begin : g_clr_wins
      always_comb q_d = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/dss_lvl_sync.sv
module dss_lvl_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= d_i[i];
    end
  end
endmodule

// File: rtl/dss_acc_gate.sv
module dss_acc_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_done_i,
  input  logic sys_rst_i,
  output logic grant_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_o <= 1'b0;
    else         grant_o <= boot_done_i & ~sys_rst_i;
  end

  // R8: grant lags the status by exactly one cycle
  p_grant_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> grant_o == $past(boot_done_i && !sys_rst_i));
endmodule

// File: rtl/dbg_sys_status.sv
module dbg_sys_status
  import dss_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h0B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              sys_rst_evt_i,
  input  logic              hold_rst_i,
  input  logic              erase_fail_evt_i,
  input  logic              boot_done_evt_i,
  input  logic              sleep_i,
  input  logic              nvm_prog_ok_i,
  input  logic              urow_prog_ok_i,
  input  logic              lock_upd_i,
  input  logic              lock_val_i,
  output logic              acc_grant_o
);
  logic             rd_hit;
  logic             rst_flag, erase_flag, boot_flag, lock_q;
  logic [LVL_W-1:0] lvl_q;
  status_t          status;

  assign rd_hit = rd_en_i && (rd_addr_i == REG_ADDR);

  // Reset flag: new event beats the clear-on-read
  dss_flag #(.SET_WINS(1'b1), .RST_VAL(1'b0)) u_rst_flag (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (sys_rst_evt_i | hold_rst_i),
    .clr_i (rd_hit),
    .q_o   (rst_flag)
  );

  // Erase failure: held reset request beats a failure event
  dss_flag #(.SET_WINS(1'b0), .RST_VAL(1'b0)) u_erase_flag (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (erase_fail_evt_i),
    .clr_i (hold_rst_i),
    .q_o   (erase_flag)
  );

  dss_flag #(.SET_WINS(1'b1), .RST_VAL(1'b0)) u_boot_flag (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .set_i (boot_done_evt_i),
    .clr_i (1'b0),
    .q_o   (boot_flag)
  );

  dss_lvl_sync #(.WIDTH(LVL_W)) u_lvl (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({sleep_i, nvm_prog_ok_i, urow_prog_ok_i}),
    .q_o   (lvl_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= STATUS_RST.locked;
    else if (lock_upd_i) lock_q <= lock_val_i;
  end

  dss_acc_gate u_gate (
    .clk_i       (clk_i), .rst_ni(rst_ni),
    .boot_done_i (boot_flag),
    .sys_rst_i   (rst_flag),
    .grant_o     (acc_grant_o)
  );

  always_comb begin
    status              = STATUS_RST;
    status.erase_fail   = erase_flag;
    status.sys_rst      = rst_flag;
    status.sleeping     = lvl_q[2];
    status.nvm_prog_ok  = lvl_q[1];
    status.urow_prog_ok = lvl_q[0];
    status.boot_done    = boot_flag;
    status.locked       = lock_q;
    status.summary      = erase_flag | boot_flag;
  end

  assign rd_data_o = rd_hit ? status : '0;

  // R4: event always lands; read clears when nothing sets
  p_rst_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_evt_i || hold_rst_i) |=> rst_flag);
  p_rst_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit && !sys_rst_evt_i && !hold_rst_i) |=> !rst_flag);
  // R9: no strobe or no match leaves the flag alone
  p_rst_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_hit && rst_flag) |=> rst_flag);
  p_miss_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> rd_data_o == 8'h00);
  // R3: held reset request wins over erase failure
  p_erase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |=> !erase_flag);
  p_erase_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_fail_evt_i && !hold_rst_i) |=> erase_flag);
  // R6: boot flag is sticky
  p_boot_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_flag |=> boot_flag);
  // R7: lock load
  p_lock_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_upd_i |=> lock_q == $past(lock_val_i));
endmodule

// File: tb/dbg_sys_status_tb_top.sv
module dbg_sys_status_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_addr_i = 8'h00;
  logic [7:0] rd_data_o;
  logic sys_rst_evt_i = 0, hold_rst_i = 0, erase_fail_evt_i = 0, boot_done_evt_i = 0;
  logic sleep_i = 0, nvm_prog_ok_i = 0, urow_prog_ok_i = 0, lock_upd_i = 0, lock_val_i = 0;
  logic acc_grant_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  dbg_sys_status dut_i (.*);

  // {sleep, nvm_prog_ok, urow_prog_ok} -> expected read word
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h01}, {3'b001, 8'h05}, {3'b010, 8'h09}, {3'b100, 8'h11},
    {3'b011, 8'h0D}, {3'b101, 8'h15}, {3'b110, 8'h19}, {3'b111, 8'h1D}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic rd(input logic [7:0] addr, input string req, input logic [7:0] exp);
    rd_en_i = 1'b1; rd_addr_i = addr;
    #1 chk(req, rd_data_o, exp);
    cyc();
    rd_en_i = 1'b0; rd_addr_i = 8'h00;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; cyc(); sig = 1'b0;
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    rd(8'h0B, "R1 reset value", 8'h01);
    chk("R1 grant after reset", {7'b0, acc_grant_o}, 8'h00);

    // R5 level walk
    foreach (VEC[i]) begin
      {sleep_i, nvm_prog_ok_i, urow_prog_ok_i} = VEC[i][10:8];
      cyc();
      rd(8'h0B, "R5 level bits", VEC[i][7:0]);
    end
    {sleep_i, nvm_prog_ok_i, urow_prog_ok_i} = 3'b000;
    cyc();

    // R4 / R9: missed reads keep the flag
    pulse(sys_rst_evt_i);
    #1 chk("R9 no strobe", rd_data_o, 8'h00);
    rd(8'h0A, "R9 other address", 8'h00);
    rd(8'h0B, "R4 read sees flag", 8'h21);
    rd(8'h0B, "R4 cleared on read", 8'h01);

    // R4 set beats clear
    pulse(sys_rst_evt_i);
    sys_rst_evt_i = 1'b1;
    rd(8'h0B, "R4 read with event", 8'h21);
    sys_rst_evt_i = 1'b0;
    rd(8'h0B, "R4 set beat clear", 8'h21);
    rd(8'h0B, "R4 clear after", 8'h01);

    // R3 held reset beats erase failure
    hold_rst_i = 1'b1;
    pulse(erase_fail_evt_i);
    rd(8'h0B, "R3 hold blocks erase flag", 8'h21);
    rd(8'h0B, "R4 hold keeps reset flag", 8'h21);
    hold_rst_i = 1'b0;
    rd(8'h0B, "R4 after hold release", 8'h21);
    rd(8'h0B, "R4 cleared after hold", 8'h01);

    // R2 / R3 erase failure sticky, then cleared by hold
    pulse(erase_fail_evt_i);
    rd(8'h0B, "R2 R3 erase failed", 8'hC1);
    rd(8'h0B, "R3 erase sticky", 8'hC1);
    pulse(hold_rst_i);
    rd(8'h0B, "R3 hold clears erase", 8'h21);
    rd(8'h0B, "R3 settle", 8'h01);

    // R6 / R8 boot and grant
    boot_done_evt_i = 1'b1;
    cyc();
    boot_done_evt_i = 1'b0;
    chk("R8 grant lags boot", {7'b0, acc_grant_o}, 8'h00);
    cyc();
    chk("R8 grant after boot", {7'b0, acc_grant_o}, 8'h01);
    rd(8'h0B, "R2 R6 boot done", 8'h83);
    pulse(sys_rst_evt_i);
    chk("R8 grant lags reset", {7'b0, acc_grant_o}, 8'h01);
    rd(8'h0B, "R6 boot sticky over reset", 8'hA3);
    chk("R8 grant removed", {7'b0, acc_grant_o}, 8'h00);
    cyc();
    chk("R8 grant restored", {7'b0, acc_grant_o}, 8'h01);

    // R7 lock load
    lock_val_i = 1'b0;
    pulse(lock_upd_i);
    rd(8'h0B, "R7 unlocked after erase", 8'h82);
    lock_val_i = 1'b1;
    pulse(lock_upd_i);
    lock_val_i = 1'b0;
    rd(8'h0B, "R7 relocked", 8'h83);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule